// File: doc/BRIEF.md
# Banked Memory Expander

This block assembles one wider and deeper synchronous memory from a grid of small single-bit banks. The address splits into two parts. The low part is sent unchanged to every bank. The high part is decoded to one-hot bank enables, so that only one row of banks is active in a cycle, which gives the added depth. Within each row, the banks sit side by side on the same address and each one stores a single bit of the data word, which gives the added width.

A cycle is a write when chip select and write enable are both high. It is a read when chip select and output enable are high and write enable is low. Read data is registered. The enable vector for a read is captured in a register, and that captured vector steers a mux that picks the output of one bank row. In every cycle that does not follow a read, the output is zero. The banks are behavioural arrays. The bank depth, the number of select bits and the data width are all parameters.

Top module: `bank_expander`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, `rdData` is zero until the first read.
- R2: At a rising clock edge where `cs` and `we` are both high, `wrData` is stored at the location given by `addr`.
- R3: A cycle with `cs`=1, `oe`=1 and `we`=0 makes `rdData` equal the word stored at `addr`, from the next rising edge until the one after it.
- R4: Address bits [BANK_AW-1:0] pick a word inside a bank. Address bits [BANK_AW+SEL_W-1:BANK_AW] are decoded so that code k enables bank row k. With the defaults, k = addr[7:6]. A write to one row never changes the same low address in any other row.
- R5: When `cs`, `we` and `oe` are all high in the same cycle, the write takes place and `rdData` is zero after that edge.
- R6: When `cs` is low, no location is written, whatever `we` and `oe` are, and `rdData` is zero after that edge.
- R7: A cycle with `cs`=1 and both `we` and `oe` low writes nothing and leaves `rdData` zero after that edge.
- R8: Bit i of the data word is held in bank column i, independently of the other bits. A word such as 4'b0001 or 4'b1000 reads back bit for bit.
- R9: At most one bank row drives `rdData` at a time. The output returns to zero in the first cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe, active high |
| oe | input | 1 | Read strobe, active high |
| addr | input | BANK_AW+SEL_W | Word address; the upper SEL_W bits select the bank row |
| wrData | input | DATA_W | Write data, one bit per bank column |
| rdData | output | DATA_W | Registered read data, zero when no read preceded |

## Verification
Every result here is due exactly one rising edge after the cycle that requests it. A write becomes visible through a read issued in any later cycle. Read data, and the zero that follows a non-read cycle, show up on `rdData` right after the capturing edge. The bench drives each cycle's inputs at a falling edge and samples `rdData` at the next falling edge, which lies half a period after the edge that registered the result, and only then applies the next cycle's inputs. Reads are only issued to locations that have already been written, so every expected value is a known word.

// File: rtl/bank_expander_pkg.sv
package bank_expander_pkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic wrStrobe;  // qualified write this cycle
    logic rdStrobe;  // qualified read this cycle
  } strobe_t;
endpackage

// File: rtl/memx_bank.sv
module memx_bank #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          rdQ
);
  localparam int DEPTH = 1 << AW;

  logic cells [DEPTH];

  always_ff @(posedge clk) begin
    if (en && wr) cells[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdQ <= 1'b0;
    else if (en && rd)   rdQ <= cells[addr];
    else                 rdQ <= 1'b0;
  end

  // R9
  idle_bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && rd) |=> (rdQ == 1'b0));
endmodule

// File: rtl/memx_ctrl.sv
module memx_ctrl
  import bank_expander_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int NUM_BANKS = 1 << SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 we,
  input  logic                 oe,
  input  logic [SEL_W-1:0]     bankSel,
  output strobe_t              strobes,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic [NUM_BANKS-1:0] rdSelQ
);
  // Write takes priority over read in the same cycle
  always_comb begin
    strobes.wrStrobe = cs && we;
    strobes.rdStrobe = cs && oe && !we;
  end

  // High address bits decoded to one-hot row enables
  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      bankEn[i] = cs && (bankSel == SEL_W'(i));
    end
  end

  // Registered row select steering the output mux
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdSelQ <= '0;
    else if (strobes.rdStrobe) rdSelQ <= bankEn;
    else                       rdSelQ <= '0;
  end

  // R4
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bankEn));

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rdSelQ));

  // R3
  sel_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && oe && !we) |=> ($countones(rdSelQ) == 1));

  // R5
  write_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we) |=> (rdSelQ == '0));

  // R6
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (rdSelQ == '0));
endmodule

// File: rtl/memx_datapath.sv
module memx_datapath
  import bank_expander_pkg::*;
#(
  parameter int BANK_AW   = 6,
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strobes,
  input  logic [NUM_BANKS-1:0] bankEn,
  input  logic [NUM_BANKS-1:0] rdSelQ,
  input  logic [BANK_AW-1:0]   rowAddr,
  input  logic [DATA_W-1:0]    din,
  output logic [DATA_W-1:0]    dout
);
  logic [NUM_BANKS-1:0][DATA_W-1:0] bankQ;

  // Rows give depth, columns give width (one bit per bank)
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
    for (genvar s = 0; s < DATA_W; s++) begin : g_col
      memx_bank #(.AW(BANK_AW)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (bankEn[b]),
        .wr   (strobes.wrStrobe),
        .rd   (strobes.rdStrobe),
        .addr (rowAddr),
        .din  (din[s]),
        .rdQ  (bankQ[b][s])
      );
    end
  end

  // Output mux steered by the registered row select
  always_comb begin
    dout = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdSelQ[b]) dout = bankQ[b];
    end
  end

  // R9
  no_select_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSelQ == '0) |-> (dout == '0));
endmodule

// File: rtl/bank_expander.sv
module bank_expander
  import bank_expander_pkg::*;
#(
  parameter int BANK_AW = 6,
  parameter int SEL_W   = 2,
  parameter int DATA_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs,
  input  logic                     we,
  input  logic                     oe,
  input  logic [BANK_AW+SEL_W-1:0] addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData
);
  localparam int NUM_BANKS = 1 << SEL_W;
  localparam int AW        = BANK_AW + SEL_W;

  strobe_t              strobes;
  logic [NUM_BANKS-1:0] bankEn;
  logic [NUM_BANKS-1:0] rdSelQ;

  memx_ctrl #(.SEL_W(SEL_W), .NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .we     (we),
    .oe     (oe),
    .bankSel(addr[AW-1:BANK_AW]),
    .strobes(strobes),
    .bankEn (bankEn),
    .rdSelQ (rdSelQ)
  );

  memx_datapath #(.BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .bankEn (bankEn),
    .rdSelQ (rdSelQ),
    .rowAddr(addr[BANK_AW-1:0]),
    .din    (wrData),
    .dout   (rdData)
  );

  // R6
  deselect_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (rdData == '0));
endmodule

// File: tb/bank_expander_tb.sv
module bank_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0, oe = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] wrData = '0;
  logic [3:0] rdData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_expander u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .oe(oe),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  // {cs, we, oe, addr[7:0], wrData[3:0], expected rdData[3:0], requirement no.}
  localparam logic [22:0] VECS [NVEC] = '{
    {3'b110, 8'h00, 4'h5, 4'h0, 4'd2},  // R2 write row 0
    {3'b110, 8'h40, 4'hA, 4'h0, 4'd2},  // R2 write row 1
    {3'b110, 8'h80, 4'h3, 4'h0, 4'd2},  // R2 write row 2
    {3'b110, 8'hC0, 4'hC, 4'h0, 4'd2},  // R2 write row 3
    {3'b101, 8'h00, 4'h0, 4'h5, 4'd3},  // R3 read row 0
    {3'b101, 8'h40, 4'h0, 4'hA, 4'd4},  // R4 no alias of row 0 into row 1
    {3'b101, 8'h80, 4'h0, 4'h3, 4'd4},  // R4
    {3'b101, 8'hC0, 4'h0, 4'hC, 4'd4},  // R4
    {3'b110, 8'h3F, 4'h1, 4'h0, 4'd8},  // R8 lowest bit only
    {3'b110, 8'hFF, 4'h8, 4'h0, 4'd8},  // R8 highest bit only
    {3'b101, 8'h3F, 4'h0, 4'h1, 4'd8},  // R8
    {3'b101, 8'hFF, 4'h0, 4'h8, 4'd8},  // R8
    {3'b101, 8'h40, 4'h0, 4'hA, 4'd4},  // R4 repeat read
    {3'b010, 8'h00, 4'hF, 4'h0, 4'd6},  // R6 deselected write
    {3'b101, 8'h00, 4'h0, 4'h5, 4'd6},  // R6 location unchanged
    {3'b111, 8'h40, 4'h6, 4'h0, 4'd5},  // R5 write wins over read
    {3'b101, 8'h40, 4'h0, 4'h6, 4'd5},  // R5 write took place
    {3'b100, 8'h80, 4'h9, 4'h0, 4'd7},  // R7 neither strobe
    {3'b101, 8'h80, 4'h0, 4'h3, 4'd7},  // R7 memory unchanged
    {3'b001, 8'h80, 4'h0, 4'h0, 4'd9}   // R9 deselected read gives zero
  };

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: rdData=%h expected=%h", req, rdData, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at the next falling edge
  task automatic cycle(input logic c, input logic w, input logic o,
                       input logic [7:0] a, input logic [3:0] d);
    cs = c; we = w; oe = o; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(4'h0, "R1");  // still in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(4'h0, "R1");  // just released

    for (int i = 0; i < NVEC; i++) begin
      cycle(VECS[i][22], VECS[i][21], VECS[i][20], VECS[i][19:12], VECS[i][11:8]);
      check(VECS[i][7:4], $sformatf("R%0d vec%0d", VECS[i][3:0], i));
    end

    // R4 alias sweep: same low address in every row, distinct words
    for (int k = 0; k < 4; k++) cycle(1'b1, 1'b1, 1'b0, {k[1:0], 6'h15}, 4'(k + 9));
    for (int k = 0; k < 4; k++) begin
      cycle(1'b1, 1'b0, 1'b1, {k[1:0], 6'h15}, 4'h0);
      check(4'(k + 9), "R4 sweep");
    end

    // R9 idle after read
    cycle(1'b1, 1'b0, 1'b1, 8'hD5, 4'h0);
    check(4'hC, "R9 read");
    cycle(1'b0, 1'b0, 1'b0, 8'h00, 4'h0);
    check(4'h0, "R9 idle");

    // R1 reset after a read clears output
    cycle(1'b1, 1'b0, 1'b1, 8'h15, 4'h0);
    check(4'h9, "R1 pre");
    cs = 1'b0; oe = 1'b0;
    rst_n = 1'b0;
    #1;
    check(4'h0, "R1 async");
    @(negedge clk);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule